// File: doc/BRIEF.md
# Erased Page Spare Detector

This block watches the spare region of a flash page while it streams past, one byte per valid beat, and decides whether the page should be handled as blank. A start strobe arms it and clears the previous verdict. Each accepted byte is counted. Any byte that is not the blank value 0xFF is counted as programmed. When the beat marked last arrives, the block compares both counts against the expected region size and the tolerance, then publishes the verdict.

The block tolerates a single stray byte, so a page with one disturbed byte in its spare region is still reported as erased. A last marker that arrives at the wrong byte count is reported as a framing error, and the erased verdict is then forced low. The verdict is also packed into a small result word at a fixed bit position, so a neighbouring block can merge it into an operation result. A clear input aborts any pass in progress.

Top module: `spare_erase_detect`

## Requirements
- R1: After reset, `erased`, `done` and `frame_err` are 0 and `status` is 0.
- R2: After `start`, a pass of exactly 64 accepted bytes that are all 0xFF, with `in_last` on the 64th, sets `erased` to 1. `done` and the verdict appear at the clock edge that accepts the last beat.
- R3: A 64-byte pass with exactly one byte other than 0xFF reports `erased`=1. A pass with two or more such bytes reports `erased`=0. The internal count of such bytes saturates at 2.
- R4: `done` is high for exactly one cycle per completed pass.
- R5: If `in_last` is accepted at any byte count other than 64, `frame_err` is 1 and `erased` is 0. A correctly sized pass leaves `frame_err` at 0.
- R6: `erased` and `frame_err` hold their values until the next `start` or `clear`. `start` resets both to 0.
- R7: `status` carries `erased` in bit 1 and `frame_err` in bit 2. Bits 0 and 3 are always 0.
- R8: `clear` ends any pass and zeroes `erased`, `frame_err` and `done`. Beats that follow it are ignored until the next `start`. `clear` takes priority over `start`.
- R9: These beats are ignored: beats with `in_valid` low, whatever the byte or last inputs are; beats while the block is not armed, before a start or after a completed pass; and a beat in the same cycle as `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms a new pass and clears the previous verdict |
| clear | input | 1 | Aborts the pass and zeroes all results |
| in_valid | input | 1 | Byte beat qualifier |
| in_byte | input | 8 | Spare byte |
| in_last | input | 1 | Marks the final byte of the region |
| erased | output | 1 | Page judged blank |
| frame_err | output | 1 | Last marker arrived at the wrong count |
| done | output | 1 | One-cycle pulse when a pass ends |
| status | output | 4 | Result word: bit 1 erased, bit 2 framing error |

## Verification
A clean pass is sent first. Then a single programmed byte is swept through all 64 positions with a different non-blank value each time, which shows that the tolerance of one holds wherever the byte sits. Pairs of programmed bytes at scattered positions, and a fully programmed region, separate a tolerance of one from a tolerance of two or more and exercise saturation. Pass lengths from 1 to 70, with and without idle gaps that carry garbage on the byte and last lines, separate correct framing from counting of unqualified beats. Stray beats after a pass, a beat that coincides with start, and an abort part-way through a pass show which beats are accepted.

// File: rtl/sdet_pkg.sv
package sdet_pkg;

  localparam int unsigned BYTE_W = 8;

  // A byte is programmed when it differs from the blank pattern.
  function automatic logic byte_dirty(input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-1:0] blank);
    return b != blank;
  endfunction

  // Increment that sticks at a ceiling.
  function automatic int unsigned sat_next(input int unsigned v,
                                           input int unsigned ceil);
    return (v < ceil) ? v + 1 : v;
  endfunction

  // Verdict for a closing beat: blank only with exact framing and tolerable misses.
  function automatic logic judge_blank(input int unsigned bytes_seen,
                                       input int unsigned misses,
                                       input int unsigned region,
                                       input int unsigned tolerance);
    return (bytes_seen == region) && (misses <= tolerance);
  endfunction

endpackage

// File: rtl/sdet_tally.sv
module sdet_tally #(
  parameter int unsigned W     = 7,
  parameter int unsigned LIMIT = 65
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero,
  input  logic         bump,
  output logic [W-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (zero)  cnt_q <= '0;
    else if (bump)  cnt_q <= W'(sdet_pkg::sat_next(32'(cnt_q), LIMIT));
  end
endmodule

// File: rtl/spare_erase_detect.sv
module spare_erase_detect #(
  parameter int unsigned REGION    = 64,
  parameter int unsigned TOLERANCE = 1,
  parameter logic [7:0]  BLANK     = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       clear,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       in_last,
  output logic       erased,
  output logic       frame_err,
  output logic       done,
  output logic [3:0] status
);
  localparam int unsigned BYTE_CEIL = REGION + 1;
  localparam int unsigned MISS_CEIL = TOLERANCE + 1;
  localparam int unsigned CW        = $clog2(BYTE_CEIL + 1);
  localparam int unsigned MW        = $clog2(MISS_CEIL + 1);

  logic          armed_q;
  logic          beat, closing, dirty, restart;
  logic [CW-1:0] byte_q;
  logic [MW-1:0] miss_q;
  int unsigned   bytes_after, miss_after;
  logic          v_blank, v_frame;

  assign restart = clear | start;
  assign beat    = armed_q & in_valid & ~restart;
  assign closing = beat & in_last;
  assign dirty   = sdet_pkg::byte_dirty(in_byte, BLANK);

  sdet_tally #(.W(CW), .LIMIT(BYTE_CEIL)) u_bytes (
    .clk(clk), .rst_n(rst_n), .zero(restart), .bump(beat), .cnt_q(byte_q));

  sdet_tally #(.W(MW), .LIMIT(MISS_CEIL)) u_miss (
    .clk(clk), .rst_n(rst_n), .zero(restart), .bump(beat & dirty), .cnt_q(miss_q));

  // Counts as they stand once the present beat is included.
  assign bytes_after = sdet_pkg::sat_next(32'(byte_q), BYTE_CEIL);
  assign miss_after  = dirty ? sdet_pkg::sat_next(32'(miss_q), MISS_CEIL) : 32'(miss_q);
  assign v_blank     = sdet_pkg::judge_blank(bytes_after, miss_after, REGION, TOLERANCE);
  assign v_frame     = bytes_after != REGION;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      erased    <= 1'b0;
      frame_err <= 1'b0;
      done      <= 1'b0;
    end else if (clear) begin
      armed_q   <= 1'b0;
      erased    <= 1'b0;
      frame_err <= 1'b0;
      done      <= 1'b0;
    end else if (start) begin
      armed_q   <= 1'b1;
      erased    <= 1'b0;
      frame_err <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= closing;
      if (closing) begin
        armed_q   <= 1'b0;
        erased    <= v_blank;
        frame_err <= v_frame;
      end
    end
  end

  // Bit 1 is the position a neighbour decodes; bit 2 carries framing.
  assign status = {1'b0, frame_err, erased, 1'b0};
endmodule

// File: rtl/sdet_checker.sv
module sdet_checker #(
  parameter int unsigned MW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          clear,
  input logic          closing,
  input logic          done,
  input logic          erased,
  input logic          frame_err,
  input logic [MW-1:0] miss_q
);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_frame_kills_blank: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !erased);

  a_r6_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !clear && !closing) |=> ($stable(erased) && $stable(frame_err)));

  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!erased && !frame_err && !done));

  a_r3_miss_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q <= MW'(2));
endmodule

bind spare_erase_detect sdet_checker #(.MW(MW)) u_sdet_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .clear(clear), .closing(closing),
  .done(done), .erased(erased), .frame_err(frame_err), .miss_q(miss_q));

// File: tb/tb_spare_erase_detect.sv
module tb_spare_erase_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, clear = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       erased, frame_err, done;
  logic [3:0] status;
  int         errors = 0, checks = 0;
  bit         finished = 0;

  always #10ns clk = ~clk;

  spare_erase_detect dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear), .in_valid(in_valid),
    .in_byte(in_byte), .in_last(in_last), .erased(erased), .frame_err(frame_err),
    .done(done), .status(status));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic beat(input logic [7:0] b, input logic last);
    in_valid = 1'b1; in_byte = b; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'h00; in_last = 1'b1; // garbage while invalid
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // One pass of len bytes; positions set in mask carry a non-blank byte.
  task automatic pass(input int len, input logic [127:0] mask,
                      input logic [7:0] badval, input bit gaps, input string tag);
    int bad = 0;
    int exp_blank, exp_fe;
    pulse_start();
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) @(negedge clk);
      beat(mask[i] ? badval : 8'hFF, i == len - 1);
      if (mask[i]) bad++;
    end
    exp_fe    = (len != 64);
    exp_blank = (len == 64) && (bad < 2);
    check({tag, " done"}, done, 1);
    check({tag, " erased"}, erased, exp_blank);
    check({tag, " R5 frame_err"}, frame_err, exp_fe);
    check({tag, " R7 status"}, status, exp_fe * 4 + exp_blank * 2);
    @(negedge clk);
    check({tag, " R4 done low"}, done, 0);
    check({tag, " R6 held"}, erased, exp_blank);
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [127:0] m;
    in_last = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 erased", erased, 0);
    check("R1 done", done, 0);
    check("R1 frame_err", frame_err, 0);
    check("R7 R1 status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);

    pass(64, '0, 8'h00, 0, "R2 clean");

    for (int p = 0; p < 64; p++) begin
      m = '0; m[p] = 1'b1;
      pass(64, m, 8'(p * 4), 0, "R3 single");
    end

    for (int p = 0; p < 64; p += 3) begin
      m = '0; m[p] = 1'b1; m[(p * 7 + 1) % 64] = 1'b1;
      pass(64, m, 8'(p + 1), 0, "R3 pair");
    end
    pass(64, {128{1'b1}}, 8'h00, 0, "R3 all dirty");
    pass(64, {128{1'b1}}, 8'hFE, 1, "R3 all dirty gaps");

    for (int len = 1; len <= 70; len++)
      if (len != 64) pass(len, '0, 8'h00, (len % 2) == 1, "R5 length");

    pass(64, '0, 8'h00, 1, "R9 gaps clean");
    m = '0; m[10] = 1'b1;
    pass(64, m, 8'h7F, 1, "R9 gaps single");

    // R6: verdict held through idle, then cleared by start.
    repeat (10) @(negedge clk);
    check("R6 idle hold", erased, 1);
    // R9: beats after a completed pass are ignored.
    for (int i = 0; i < 5; i++) beat(8'h00, i == 4);
    check("R9 stray done", done, 0);
    check("R9 stray erased", erased, 1);
    pulse_start();
    check("R6 start clears erased", erased, 0);
    check("R6 start clears frame_err", frame_err, 0);

    // Frame error held until start.
    pass(10, '0, 8'h00, 0, "R5 short");
    repeat (5) @(negedge clk);
    check("R6 frame hold", frame_err, 1);

    // R9: a beat coinciding with start is dropped.
    start = 1'b1; in_valid = 1'b1; in_byte = 8'h00; in_last = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 64; i++) beat(8'hFF, i == 63);
    check("R9 start beat dropped erased", erased, 1);
    check("R9 start beat dropped frame_err", frame_err, 0);
    @(negedge clk);

    // R8: clear aborts; following beats ignored.
    pulse_start();
    for (int i = 0; i < 10; i++) beat(8'hFF, 1'b0);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R8 clear erased", erased, 0);
    check("R8 clear done", done, 0);
    for (int i = 0; i < 54; i++) beat(8'hFF, i == 53);
    check("R8 ignored done", done, 0);
    check("R8 ignored erased", erased, 0);
    check("R8 ignored frame_err", frame_err, 0);

    // R8: clear wins over start, after a clean verdict.
    pass(64, '0, 8'h00, 0, "R2 again");
    clear = 1'b1; start = 1'b1;
    @(negedge clk);
    clear = 1'b0; start = 1'b0;
    for (int i = 0; i < 64; i++) beat(8'hFF, i == 63);
    check("R8 clear over start done", done, 0);
    check("R8 clear over start erased", erased, 0);

    summary();
  end
endmodule